// File: doc/BRIEF.md
# Voice sample serial port with linear and A-law word formats

This block moves one voice sample per 8 kHz frame in each direction over a serial bit stream. The transmit half takes a 13-bit two's complement sample from the codec datapath. It shifts the sample out most significant bit first, either as a 16-bit linear word or as an 8-bit A-law code. The receive half shifts a word in and presents it as a 13-bit linear sample. A-law input is expanded to the midpoint of its quantisation interval. Transmit and receive each have their own frame strobe. Both follow one shared bit clock, and that clock is sampled in the system clock domain.

A single mode input selects the word alignment. With non-delayed alignment, the first bit occupies the bit period in which the strobe is high. With delayed alignment, the first bit occupies the period that follows. The transmit output-enable stays low while the transmit channel is disabled. It also stays low through the whole first frame after enabling, and it is raised only from the second strobe onward, during the bits of the word.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, tx_oe is 0, rx_valid is 0 and rx_sample is 0.
- R2: With fmt_alaw = 0 the transmit word is 16 bits, MSB first. Bits 15:3 carry the 13-bit two's complement sample and bits 2:0 are sent as 0.
- R3: With fmt_alaw = 1 the transmit word is an 8-bit A-law code, MSB first. The code is built as {sign, segment[2:0], mantissa[3:0]}, where sign is 1 for a non-negative sample and negative samples use the ones' complement magnitude. The code is then XORed with 8'h55 before it is sent.
- R4: With fmt_alaw = 0, 16 bits are received MSB first. rx_sample takes received bits 15:3, and the last three bits received have no effect on it.
- R5: With fmt_alaw = 1, 8 bits are received and expanded. The code is first XORed with 8'h55. Segment 0 gives magnitude 2*mantissa+1, and segment s > 0 gives (2*mantissa+33)·2^(s-1). A sign bit of 0 gives the value -magnitude-1.
- R6: With sync_dly = 0, the MSB is driven in the bit period in which the frame strobe is high, and the MSB is received in that same period.
- R7: With sync_dly = 1, the MSB is driven and received one bit period after the one in which the strobe is high.
- R8: tx_dout and tx_oe change only after a rising bit-clock edge. Received bits and rx_valid are taken only on falling bit-clock edges.
- R9: After tx_en rises, tx_oe stays 0 for the whole first frame. From the second strobe onward, tx_oe is 1 for exactly the bit periods of the word and 0 outside them.
- R10: While tx_en is 0, tx_oe is 0 from the next cycle on. Enabling again requires two more strobes before tx_oe rises.
- R11: While rx_en is 0, rx_valid stays 0 and rx_sample keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, synchronous to clk |
| tx_fs | input | 1 | Transmit frame strobe |
| rx_fs | input | 1 | Receive frame strobe |
| tx_en | input | 1 | Transmit channel enable (0 = powered down) |
| rx_en | input | 1 | Receive channel enable (0 = powered down) |
| fmt_alaw | input | 1 | Word format: 0 = 16-bit linear, 1 = 8-bit A-law |
| sync_dly | input | 1 | Alignment: 0 = non-delayed, 1 = delayed by one bit |
| tx_sample | input | 13 | Sample to send, two's complement |
| rx_din | input | 1 | Serial receive data |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for tx_dout (0 = high impedance) |
| rx_sample | output | 13 | Last received sample, two's complement |
| rx_valid | output | 1 | One-cycle pulse when rx_sample is updated |

## Verification
The embedded assertions check four properties on every cycle. They check that the output-enable falls after the transmit channel is disabled. They check that transmit data holds steady except after a rising bit-clock edge. They check that the enable can only rise once a strobe has already been counted. They check that received words complete only on falling edges and never while the receive channel is disabled. Several properties need the bench's frame scenarios instead. These are the bit order and the word contents in both formats, the A-law compression and expansion values at the segment extremes, the one-bit offset of the delayed alignment, and the two-frame hold-off after each enable.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W = 13;
    localparam int WORD_W   = 16;
    localparam int CODE_W   = 8;
    localparam int PAD_W    = WORD_W - SAMPLE_W;
    localparam int LEFT_W   = $clog2(WORD_W);

    typedef enum logic {
        FMT_LINEAR = 1'b0,
        FMT_ALAW   = 1'b1
    } pcm_fmt_e;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]   code_t;

    // Segment-encoded compression of a 13-bit two's complement sample.
    function automatic code_t alaw_compress(input sample_t s);
        logic [SAMPLE_W-2:0] mag;
        logic [2:0]          seg;
        logic [3:0]          man;
        logic                pos;
        pos = ~s[SAMPLE_W-1];
        mag = s[SAMPLE_W-1] ? ~s[SAMPLE_W-2:0] : s[SAMPLE_W-2:0];
        seg = 3'd0;
        for (int b = 5; b <= 11; b++) begin
            if (mag[b]) seg = 3'(b - 4);
        end
        man = (seg == 3'd0) ? mag[4:1] : 4'(mag >> seg);
        return {pos, seg, man} ^ 8'h55;
    endfunction

    // Expansion to the midpoint of the code's quantisation interval.
    function automatic sample_t alaw_expand(input code_t code);
        code_t               c;
        logic [2:0]          seg;
        logic [SAMPLE_W-2:0] mag;
        c   = code ^ 8'h55;
        seg = c[6:4];
        if (seg == 3'd0)
            mag = {7'b0, c[3:0], 1'b1};
        else
            mag = 12'({6'b0, 1'b1, c[3:0], 1'b1} << (seg - 3'd1));
        return c[7] ? {1'b0, mag} : {1'b1, ~mag};
    endfunction

endpackage

// File: rtl/pcm_sync_track.sv
module pcm_sync_track #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_rise,
    input  logic             fs,
    output logic [DEPTH-1:0] hist
);
    // hist[0] is the strobe of the latest bit period, hist[k] is k periods older.
    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (bit_rise)
            hist <= {hist[DEPTH-2:0], fs};
    end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_rise,
    input  logic     fs,
    input  logic [1:0] hist,
    input  logic     dly,
    input  pcm_fmt_e fmt,
    input  logic     en,
    input  sample_t  sample,
    output logic     dout,
    output logic     oe
);
    logic [WORD_W-1:0] sr;
    logic [LEFT_W-1:0] left;
    logic              busy;
    logic [1:0]        arm;
    logic              start;

    assign start = bit_rise & (dly ? (hist[0] & ~hist[1]) : (fs & ~hist[0]));
    assign dout  = sr[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sr   <= '0;
            left <= '0;
            busy <= 1'b0;
            arm  <= 2'd0;
            oe   <= 1'b0;
        end else if (start) begin
            if (fmt == FMT_ALAW) begin
                sr   <= {alaw_compress(sample), {(WORD_W-CODE_W){1'b0}}};
                left <= LEFT_W'(CODE_W - 1);
            end else begin
                sr   <= {sample, {PAD_W{1'b0}}};
                left <= LEFT_W'(WORD_W - 1);
            end
            busy <= 1'b1;
            oe   <= (arm != 2'd0);
            arm  <= (arm == 2'd2) ? 2'd2 : arm + 2'd1;
        end else if (bit_rise && busy) begin
            if (left == '0) begin
                busy <= 1'b0;
                oe   <= 1'b0;
            end else begin
                sr   <= {sr[WORD_W-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end

    // R10: a disabled channel releases the line on the next cycle
    a_r10_pdown_release: assert property (@(posedge clk) disable iff (rst)
        !en |=> !oe);

    // R8: serial data moves only after a rising bit-clock edge while enabled
    a_r8_tx_rise_only: assert property (@(posedge clk) disable iff (rst)
        (!bit_rise && en) |=> $stable(dout));

    // R9: the line is driven only on a rising edge once a strobe was already counted
    a_r9_oe_after_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> ($past(bit_rise) && $past(arm) != 2'd0));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_fall,
    input  logic [2:0] hist,
    input  logic     dly,
    input  pcm_fmt_e fmt,
    input  logic     en,
    input  logic     din,
    output sample_t  sample,
    output logic     valid
);
    logic [WORD_W-2:0] sr;
    logic [LEFT_W-1:0] left;
    logic              busy;
    logic              start;

    assign start = bit_fall & (dly ? (hist[1] & ~hist[2]) : (hist[0] & ~hist[1]));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            left   <= '0;
            busy   <= 1'b0;
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en) begin
                busy <= 1'b0;
                left <= '0;
            end else if (start) begin
                sr   <= {sr[WORD_W-3:0], din};
                left <= (fmt == FMT_ALAW) ? LEFT_W'(CODE_W - 2) : LEFT_W'(WORD_W - 2);
                busy <= 1'b1;
            end else if (bit_fall && busy) begin
                sr <= {sr[WORD_W-3:0], din};
                if (left == '0) begin
                    busy   <= 1'b0;
                    valid  <= 1'b1;
                    sample <= (fmt == FMT_ALAW) ? alaw_expand({sr[CODE_W-2:0], din})
                                                : sr[WORD_W-2:PAD_W-1];
                end else begin
                    left <= left - 1'b1;
                end
            end
        end
    end

    // R8: a word completes only on a falling bit-clock edge
    a_r8_rx_fall_only: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(bit_fall));

    // R11: no word completes while the receive channel is disabled
    a_r11_rx_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk,
    input  logic                tx_fs,
    input  logic                rx_fs,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                fmt_alaw,
    input  logic                sync_dly,
    input  logic [SAMPLE_W-1:0] tx_sample,
    input  logic                rx_din,
    output logic                tx_dout,
    output logic                tx_oe,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    logic     bclk_q;
    logic     bit_rise;
    logic     bit_fall;
    pcm_fmt_e fmt;
    logic [1:0] tx_hist;
    logic [2:0] rx_hist;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    assign bit_rise = bclk & ~bclk_q;
    assign bit_fall = ~bclk & bclk_q;
    assign fmt      = pcm_fmt_e'(fmt_alaw);

    pcm_sync_track #(.DEPTH(2)) u_tx_sync (
        .clk(clk), .rst(rst), .bit_rise(bit_rise), .fs(tx_fs), .hist(tx_hist)
    );

    pcm_sync_track #(.DEPTH(3)) u_rx_sync (
        .clk(clk), .rst(rst), .bit_rise(bit_rise), .fs(rx_fs), .hist(rx_hist)
    );

    pcm_tx_lane u_tx (
        .clk(clk), .rst(rst), .bit_rise(bit_rise), .fs(tx_fs), .hist(tx_hist),
        .dly(sync_dly), .fmt(fmt), .en(tx_en), .sample(tx_sample),
        .dout(tx_dout), .oe(tx_oe)
    );

    pcm_rx_lane u_rx (
        .clk(clk), .rst(rst), .bit_fall(bit_fall), .hist(rx_hist),
        .dly(sync_dly), .fmt(fmt), .en(rx_en), .din(rx_din),
        .sample(rx_sample), .valid(rx_valid)
    );
endmodule

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        bclk, tx_fs, rx_fs, tx_en, rx_en, fmt_alaw, sync_dly, rx_din;
    logic [12:0] tx_sample;
    logic        tx_dout, tx_oe, rx_valid;
    logic [12:0] rx_sample;

    int checks = 0;
    int fails  = 0;
    int r8_bad = 0;
    logic valid_seen;
    logic done = 1'b0;

    always #4 clk = ~clk;

    pcm_serial_port u0 (
        .clk(clk), .rst(rst), .bclk(bclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
        .tx_en(tx_en), .rx_en(rx_en), .fmt_alaw(fmt_alaw), .sync_dly(sync_dly),
        .tx_sample(tx_sample), .rx_din(rx_din), .tx_dout(tx_dout), .tx_oe(tx_oe),
        .rx_sample(rx_sample), .rx_valid(rx_valid)
    );

    always @(posedge clk) if (rx_valid) valid_seen = 1'b1;

    // fields: [30] A-law, [29] delayed, [28:16] transmit sample, [15:0] received word
    localparam logic [30:0] VEC [0:9] = '{
        {1'b0, 1'b0, 13'h0A5B, 16'h8F38},
        {1'b0, 1'b1, 13'h1000, 16'h7FF8},
        {1'b0, 1'b0, 13'h0FFF, 16'hFFFF},
        {1'b1, 1'b0, 13'h0000, 16'hD500},
        {1'b1, 1'b1, 13'h1FFF, 16'h5500},
        {1'b1, 1'b0, 13'h0FFF, 16'hAA00},
        {1'b1, 1'b1, 13'h1000, 16'h2A00},
        {1'b1, 1'b0, 13'h0123, 16'h3C00},
        {1'b0, 1'b1, 13'h1555, 16'h1234},
        {1'b1, 1'b1, 13'h07C0, 16'hC7A5}
    };

    function automatic logic [7:0] ref_compress(input logic [12:0] s);
        int v, m, seg, man;
        bit nonneg;
        v = int'($signed(s));
        if (v >= 0) begin m = v; nonneg = 1; end
        else begin m = -v - 1; nonneg = 0; end
        seg = 0;
        while (seg < 7 && m >= (32 << seg)) seg++;
        man = (seg == 0) ? m / 2 : (m >> seg) % 16;
        return 8'(((nonneg ? 128 : 0) + seg * 16 + man) ^ 'h55);
    endfunction

    function automatic logic [12:0] ref_expand(input logic [7:0] code);
        int c, seg, man, mag;
        c   = int'(code) ^ 'h55;
        seg = (c / 16) % 8;
        man = c % 16;
        mag = (seg == 0) ? 2 * man + 1 : (2 * man + 33) * (1 << (seg - 1));
        return (c >= 128) ? 13'(mag) : 13'(-mag - 1);
    endfunction

    task automatic bit_period(input logic tfs, input logic rfs, input logic rd,
                              output logic sd, output logic so);
        @(negedge clk);
        bclk = 1'b1; tx_fs = tfs; rx_fs = rfs; rx_din = rd;
        @(negedge clk);
        @(negedge clk);
        sd = tx_dout; so = tx_oe;
        bclk = 1'b0;
        @(negedge clk);
        // R8: nothing on the transmit pins may move across the falling edge
        if (tx_dout !== sd || tx_oe !== so) r8_bad++;
    endtask

    task automatic run_frame(input logic alaw, input logic dly, input logic [12:0] txs,
                             input logic [15:0] rxw, input logic live,
                             input logic rx_on, input logic [12:0] rx_hold);
        int len, off;
        logic [15:0] tx_exp, tx_got;
        logic sd, so, oe_ok;
        logic [12:0] rx_exp;
        fmt_alaw = alaw; sync_dly = dly; tx_sample = txs;
        len = alaw ? 8 : 16;
        off = dly ? 1 : 0;
        tx_exp = alaw ? {ref_compress(txs), 8'h00} : {txs, 3'b000};
        tx_got = '0;
        oe_ok = 1'b1;
        valid_seen = 1'b0;
        for (int p = 0; p < 20; p++) begin
            logic in_win;
            in_win = (p >= off) && (p < off + len);
            bit_period(p == 0, p == 0, in_win ? rxw[15 - (p - off)] : 1'b0, sd, so);
            if (in_win) begin
                tx_got[15 - (p - off)] = sd;
                if (so !== live) oe_ok = 1'b0;
            end else if (so !== 1'b0) begin
                oe_ok = 1'b0;
            end
        end
        // R9 R10 enable window, R2 or R3 word, R6 or R7 alignment
        checks++;
        if (!oe_ok || (live && tx_got !== tx_exp)) begin
            fails++;
            $display("FAIL %s tx (%s, R9 R10) live=%0b: got %h exp %h oe_ok=%0b",
                     alaw ? "R3" : "R2", dly ? "R7" : "R6", live, tx_got, tx_exp, oe_ok);
        end
        // R4 or R5 receive value, R11 when disabled
        rx_exp = !rx_on ? rx_hold : (alaw ? ref_expand(rxw[15:8]) : rxw[15:3]);
        checks++;
        if (rx_sample !== rx_exp || valid_seen !== rx_on) begin
            fails++;
            $display("FAIL %s rx (%s, R11) en=%0b: got %h valid=%0b exp %h valid=%0b",
                     alaw ? "R5" : "R4", dly ? "R7" : "R6", rx_on,
                     rx_sample, valid_seen, rx_exp, rx_on);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bclk = 1'b0; tx_fs = 1'b0; rx_fs = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
        fmt_alaw = 1'b0; sync_dly = 1'b0; tx_sample = '0; rx_din = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (tx_oe !== 1'b0 || rx_valid !== 1'b0 || rx_sample !== 13'h0) begin
            fails++;
            $display("FAIL R1 reset: got oe=%0b valid=%0b sample=%h exp 0 0 0",
                     tx_oe, rx_valid, rx_sample);
        end

        tx_en = 1'b1; rx_en = 1'b1;
        // R9: first frame after enable keeps the line released
        run_frame(1'b0, 1'b0, 13'h0333, 16'h4448, 1'b0, 1'b1, 13'h0);

        for (int i = 0; i < 10; i++)
            run_frame(VEC[i][30], VEC[i][29], VEC[i][28:16], VEC[i][15:0], 1'b1, 1'b1, 13'h0);

        // R10: power down releases the line, re-enable needs two strobes again
        tx_en = 1'b0;
        run_frame(1'b0, 1'b0, 13'h0F0F, 16'h2220, 1'b0, 1'b1, 13'h0);
        tx_en = 1'b1;
        run_frame(1'b1, 1'b0, 13'h0F0F, 16'h8000, 1'b0, 1'b1, 13'h0);
        run_frame(1'b1, 1'b0, 13'h1F00, 16'hFF00, 1'b1, 1'b1, 13'h0);

        // R11: disabled receiver holds the last sample (expansion of 8'hFF)
        rx_en = 1'b0;
        run_frame(1'b0, 1'b1, 13'h0101, 16'h0008, 1'b1, 1'b0, ref_expand(8'hFF));
        rx_en = 1'b1;
        run_frame(1'b0, 1'b1, 13'h1ABC, 16'hABC8, 1'b1, 1'b1, 13'h0);

        // R8: transmit pins never moved across a falling bit-clock edge
        checks++;
        if (r8_bad != 0) begin
            fails++;
            $display("FAIL R8 tx moved on falling edge: got %0d changes exp 0", r8_bad);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule